// File: doc/BRIEF.md
# Lockable Fully Associative Translation Buffer

This block caches page translations for data accesses. A request carries a virtual page number together with the access type: write or read, privileged or user. The page number is compared against every stored entry in the same cycle. A hit returns the stored physical page, the domain number, the 2-bit access-permission code and the attribute bits. A miss stalls the requester. The block then asks an external walker for a descriptor over a request/acknowledge handshake, writes that descriptor into a victim slot, and repeats the lookup on its own. The repeated lookup uses the translation it has just written.

Victim slots rotate round-robin. A lock base L keeps the low entries 0 to L-1 pinned: those entries are never replaced and survive a partial flush. Every translated access also goes through a check against a per-domain control word, and a violation raises an abort flag on the response. When translation is switched off, the physical page equals the virtual page and no abort is raised.

Top module: `locked_xlat_buffer`

## Requirements
- R1: After reset, req_ready is 1, resp_valid is 0, walk_req is 0, and every entry is invalid, so the first lookup of any page misses.
- R2: An accepted lookup (mmu_en=1) that matches no valid entry raises walk_req on the next clock edge, with walk_vpn equal to the requested page. Both hold until walk_ack, and req_ready stays 0 until the response.
- R3: On the edge that samples walk_ack, the descriptor is written into the victim slot. resp_valid rises on the following edge with resp_hit=0 and the newly written fields. No second walk occurs.
- R4: An accepted lookup that matches a valid entry gives resp_valid=1 and resp_hit=1 one edge later, with the stored physical page, domain, permission code and attributes. No walk occurs, and at most one entry ever matches.
- R5: With lock base 0, fills occupy slots 0,1,…,N-1 in order and then wrap to slot 0.
- R6: Fills never go to an entry below lock base L. The victim is max(pointer, L), and after slot N-1 the pointer wraps to L.
- R7: A pulse on inv_unlk clears the valid bit of every entry at index L or above. Entries below L stay valid.
- R8: A pulse on inv_all clears the valid bit of every entry.
- R9: The domain field for domain d is dom_ctl[2d+1:2d]. Codes 00 and 10 always abort, 11 never aborts, and 01 applies the permission-code check of R10.
- R10: Permission codes: 00 allows a privileged read only; 01 allows privileged read and write; 10 allows privileged read and write plus user read; 11 allows everything. Any other access aborts.
- R11: With mmu_en=0, an accepted lookup gives resp_valid=1 one edge later, with resp_hit=1, resp_ppn equal to req_vpn, resp_abort=0 and domain, permission and attributes all 0. No walk occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mmu_en | input | 1 | Translation and permission check enable |
| lk_base | input | IDX_W | Lock base L; entries below it are pinned |
| dom_ctl | input | 2*DOMS | Two-bit control field per domain |
| inv_unlk | input | 1 | Invalidate unlocked entries |
| inv_all | input | 1 | Invalidate every entry |
| req_valid | input | 1 | Lookup request |
| req_ready | output | 1 | Block idle and able to accept a request |
| req_vpn | input | PN_W | Virtual page number |
| req_write | input | 1 | Access is a write |
| req_priv | input | 1 | Access is privileged |
| resp_valid | output | 1 | One-cycle response strobe |
| resp_hit | output | 1 | Response came from an existing entry (or bypass) |
| resp_abort | output | 1 | Permission violation |
| resp_ppn | output | PN_W | Physical page number |
| resp_dom | output | DOM_W | Domain of the entry |
| resp_ap | output | 2 | Permission code of the entry |
| resp_attr | output | ATTR_W | Cache/buffer attributes |
| walk_req | output | 1 | Descriptor fetch request |
| walk_vpn | output | PN_W | Page being walked |
| walk_ack | input | 1 | Descriptor returned |
| walk_ppn | input | PN_W | Descriptor physical page |
| walk_dom | input | DOM_W | Descriptor domain |
| walk_ap | input | 2 | Descriptor permission code |
| walk_attr | input | ATTR_W | Descriptor attributes |

## Verification
The bench builds the block with 8 entries, 10-bit page numbers, 16 domains and 4 attribute bits. With only eight slots, a full round-robin wrap, a wrap back to a non-zero lock base and eviction of the oldest unlocked page all happen within a few dozen lookups. Each of these shows up at the ports as a miss or a hit on a known page. All 16 domains are kept, so the full 32-bit domain control word and the reserved code are exercised at their real width.

// File: rtl/lxb_pkg.sv
// Shared types for the lockable translation buffer.
// Holds the domain control codes, the controller states and the
// permission-code decision, which is used by the permission checker.
package lxb_pkg;

    typedef enum logic [1:0] {
        DA_NONE    = 2'b00,
        DA_CLIENT  = 2'b01,
        DA_RSVD    = 2'b10,
        DA_MANAGER = 2'b11
    } dom_acc_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'b00,
        ST_WALK   = 2'b01,
        ST_REPLAY = 2'b10
    } lxb_state_e;

    // True when the permission code allows this access type.
    function automatic logic ap_permits(input logic [1:0] ap,
                                        input logic wr,
                                        input logic priv);
        logic ok;
        case (ap)
            2'b00:   ok = priv & ~wr;
            2'b01:   ok = priv;
            2'b10:   ok = priv | ~wr;
            default: ok = 1'b1;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/lxb_cam.sv
// Fully associative entry store with parallel match.
// Each entry holds a valid bit, virtual page, physical page, domain,
// permission code and attributes. Assumes the controller writes only on a
// miss, so at most one entry matches. Invalidation wins over a write that
// falls in the same cycle.
module lxb_cam #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5,
    parameter int PN_W    = 20,
    parameter int DOM_W   = 4,
    parameter int ATTR_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   lk_base,
    input  logic               inv_all,
    input  logic               inv_unlk,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_idx,
    input  logic [PN_W-1:0]    wr_vpn,
    input  logic [PN_W-1:0]    wr_ppn,
    input  logic [DOM_W-1:0]   wr_dom,
    input  logic [1:0]         wr_ap,
    input  logic [ATTR_W-1:0]  wr_attr,
    input  logic [PN_W-1:0]    look_vpn,
    output logic               hit,
    output logic [ENTRIES-1:0] match_vec,
    output logic [PN_W-1:0]    hit_ppn,
    output logic [DOM_W-1:0]   hit_dom,
    output logic [1:0]         hit_ap,
    output logic [ATTR_W-1:0]  hit_attr
);

    logic [PN_W-1:0]   ppn_sel  [ENTRIES];
    logic [DOM_W-1:0]  dom_sel  [ENTRIES];
    logic [1:0]        ap_sel   [ENTRIES];
    logic [ATTR_W-1:0] attr_sel [ENTRIES];

    for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
        localparam logic [IDX_W-1:0] IDX = IDX_W'(g);
        logic              v_q;
        logic [PN_W-1:0]   vpn_q;
        logic [PN_W-1:0]   ppn_q;
        logic [DOM_W-1:0]  dom_q;
        logic [1:0]        ap_q;
        logic [ATTR_W-1:0] attr_q;
        logic              sel;

        // Valid bit: reset and flushes clear it, a fill sets it.
        always_ff @(posedge clk) begin
            if (!rst_n)                           v_q <= 1'b0;
            else if (inv_all)                     v_q <= 1'b0;
            else if (inv_unlk && IDX >= lk_base)  v_q <= 1'b0;
            else if (wr_en && wr_idx == IDX)      v_q <= 1'b1;
        end

        // Payload: loaded from the descriptor when this slot is the victim.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vpn_q  <= '0;
                ppn_q  <= '0;
                dom_q  <= '0;
                ap_q   <= '0;
                attr_q <= '0;
            end else if (wr_en && wr_idx == IDX) begin
                vpn_q  <= wr_vpn;
                ppn_q  <= wr_ppn;
                dom_q  <= wr_dom;
                ap_q   <= wr_ap;
                attr_q <= wr_attr;
            end
        end

        assign sel          = v_q && (vpn_q == look_vpn);
        assign match_vec[g] = sel;
        assign ppn_sel[g]   = sel ? ppn_q  : '0;
        assign dom_sel[g]   = sel ? dom_q  : '0;
        assign ap_sel[g]    = sel ? ap_q   : '0;
        assign attr_sel[g]  = sel ? attr_q : '0;
    end

    // OR-reduce the masked payloads of the (at most one) matching entry.
    always_comb begin
        hit_ppn  = '0;
        hit_dom  = '0;
        hit_ap   = '0;
        hit_attr = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            hit_ppn  = hit_ppn  | ppn_sel[i];
            hit_dom  = hit_dom  | dom_sel[i];
            hit_ap   = hit_ap   | ap_sel[i];
            hit_attr = hit_attr | attr_sel[i];
        end
    end

    assign hit = |match_vec;

endmodule

// File: rtl/lxb_victim.sv
// Round-robin victim selection above a lock base.
// The victim is the rotating pointer, raised to the lock base when it sits
// below it. After the last entry the pointer wraps to the lock base.
// Assumes ENTRIES is a power of two, so lk_base never exceeds ENTRIES-1.
module lxb_victim #(
    parameter int ENTRIES = 32,
    parameter int IDX_W   = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_base,
    input  logic             advance,
    output logic [IDX_W-1:0] victim
);

    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    // Clamp the pointer into the unlocked region.
    always_comb victim = (ptr_q < lk_base) ? lk_base : ptr_q;

    // Step past the slot that was just filled, wrapping to the lock base.
    always_ff @(posedge clk) begin
        if (!rst_n)       ptr_q <= '0;
        else if (advance) ptr_q <= (victim == LAST) ? lk_base : victim + 1'b1;
    end

endmodule

// File: rtl/lxb_perm.sv
// Domain and permission-code check for one translated access.
// Reads the 2-bit field of the entry's domain: no-access and reserved codes
// abort, manager passes, client defers to the entry's permission code.
// Produces no abort while translation is disabled.
module lxb_perm
    import lxb_pkg::*;
#(
    parameter int DOMS  = 16,
    parameter int DOM_W = 4
) (
    input  logic              mmu_en,
    input  logic [2*DOMS-1:0] dom_ctl,
    input  logic [DOM_W-1:0]  dom,
    input  logic [1:0]        ap,
    input  logic              wr,
    input  logic              priv,
    output logic              abort
);

    dom_acc_e mode;

    // Decode the selected domain field and decide the abort.
    always_comb begin
        mode = dom_acc_e'(dom_ctl[2*int'(dom) +: 2]);
        case (mode)
            DA_MANAGER: abort = 1'b0;
            DA_CLIENT:  abort = ~ap_permits(ap, wr, priv);
            default:    abort = 1'b1;
        endcase
        if (!mmu_en) abort = 1'b0;
    end

endmodule

// File: rtl/locked_xlat_buffer.sv
// Lockable fully associative translation buffer (top).
// Accepts one lookup at a time. A hit answers on the next edge. A miss runs
// a descriptor walk over walk_req/walk_ack, fills the round-robin victim,
// then repeats the lookup internally. Every translated response carries a
// domain permission verdict. Inputs are assumed synchronous to clk.
module locked_xlat_buffer
    import lxb_pkg::*;
#(
    parameter int ENTRIES = 32,
    parameter int PN_W    = 20,
    parameter int DOMS    = 16,
    parameter int ATTR_W  = 4,
    localparam int IDX_W  = $clog2(ENTRIES),
    localparam int DOM_W  = $clog2(DOMS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mmu_en,
    input  logic [IDX_W-1:0]  lk_base,
    input  logic [2*DOMS-1:0] dom_ctl,
    input  logic              inv_unlk,
    input  logic              inv_all,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [PN_W-1:0]   req_vpn,
    input  logic              req_write,
    input  logic              req_priv,
    output logic              resp_valid,
    output logic              resp_hit,
    output logic              resp_abort,
    output logic [PN_W-1:0]   resp_ppn,
    output logic [DOM_W-1:0]  resp_dom,
    output logic [1:0]        resp_ap,
    output logic [ATTR_W-1:0] resp_attr,
    output logic              walk_req,
    output logic [PN_W-1:0]   walk_vpn,
    input  logic              walk_ack,
    input  logic [PN_W-1:0]   walk_ppn,
    input  logic [DOM_W-1:0]  walk_dom,
    input  logic [1:0]        walk_ap,
    input  logic [ATTR_W-1:0] walk_attr
);

    lxb_state_e        state_q;
    logic [PN_W-1:0]   held_vpn_q;
    logic              held_wr_q;
    logic              held_priv_q;

    logic [PN_W-1:0]   look_vpn;
    logic              look_wr;
    logic              look_priv;
    logic              accept;
    logic              fill;
    logic [IDX_W-1:0]  fill_idx;

    logic              hit;
    logic [ENTRIES-1:0] match_vec;
    logic [PN_W-1:0]   hit_ppn;
    logic [DOM_W-1:0]  hit_dom;
    logic [1:0]        hit_ap;
    logic [ATTR_W-1:0] hit_attr;
    logic              perm_abort;

    // Choose the lookup source: live request when idle, held request on replay.
    always_comb begin
        if (state_q == ST_REPLAY) begin
            look_vpn  = held_vpn_q;
            look_wr   = held_wr_q;
            look_priv = held_priv_q;
        end else begin
            look_vpn  = req_vpn;
            look_wr   = req_write;
            look_priv = req_priv;
        end
    end

    assign req_ready = (state_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign walk_req  = (state_q == ST_WALK);
    assign walk_vpn  = held_vpn_q;
    assign fill      = walk_req && walk_ack;

    lxb_cam #(
        .ENTRIES(ENTRIES), .IDX_W(IDX_W), .PN_W(PN_W),
        .DOM_W(DOM_W), .ATTR_W(ATTR_W)
    ) u_cam (
        .clk(clk), .rst_n(rst_n), .lk_base(lk_base),
        .inv_all(inv_all), .inv_unlk(inv_unlk),
        .wr_en(fill), .wr_idx(fill_idx),
        .wr_vpn(held_vpn_q), .wr_ppn(walk_ppn), .wr_dom(walk_dom),
        .wr_ap(walk_ap), .wr_attr(walk_attr),
        .look_vpn(look_vpn), .hit(hit), .match_vec(match_vec),
        .hit_ppn(hit_ppn), .hit_dom(hit_dom), .hit_ap(hit_ap),
        .hit_attr(hit_attr)
    );

    lxb_victim #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_victim (
        .clk(clk), .rst_n(rst_n), .lk_base(lk_base),
        .advance(fill), .victim(fill_idx)
    );

    lxb_perm #(.DOMS(DOMS), .DOM_W(DOM_W)) u_perm (
        .mmu_en(mmu_en), .dom_ctl(dom_ctl), .dom(hit_dom), .ap(hit_ap),
        .wr(look_wr), .priv(look_priv), .abort(perm_abort)
    );

    // Controller: accept, walk on miss, replay after fill, register the response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            held_vpn_q  <= '0;
            held_wr_q   <= 1'b0;
            held_priv_q <= 1'b0;
            resp_valid  <= 1'b0;
            resp_hit    <= 1'b0;
            resp_abort  <= 1'b0;
            resp_ppn    <= '0;
            resp_dom    <= '0;
            resp_ap     <= '0;
            resp_attr   <= '0;
        end else begin
            resp_valid <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (accept) begin
                        held_vpn_q  <= req_vpn;
                        held_wr_q   <= req_write;
                        held_priv_q <= req_priv;
                        if (!mmu_en) begin
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b1;
                            resp_abort <= 1'b0;
                            resp_ppn   <= req_vpn;
                            resp_dom   <= '0;
                            resp_ap    <= '0;
                            resp_attr  <= '0;
                        end else if (hit) begin
                            resp_valid <= 1'b1;
                            resp_hit   <= 1'b1;
                            resp_abort <= perm_abort;
                            resp_ppn   <= hit_ppn;
                            resp_dom   <= hit_dom;
                            resp_ap    <= hit_ap;
                            resp_attr  <= hit_attr;
                        end else begin
                            state_q <= ST_WALK;
                        end
                    end
                end
                ST_WALK: begin
                    if (walk_ack) state_q <= ST_REPLAY;
                end
                ST_REPLAY: begin
                    if (hit) begin
                        resp_valid <= 1'b1;
                        resp_hit   <= 1'b0;
                        resp_abort <= perm_abort;
                        resp_ppn   <= hit_ppn;
                        resp_dom   <= hit_dom;
                        resp_ap    <= hit_ap;
                        resp_attr  <= hit_attr;
                        state_q    <= ST_IDLE;
                    end else begin
                        state_q <= ST_WALK;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/lxb_checker.sv
// Protocol and structural properties of the translation buffer.
// Observes ports plus the match vector and the fill write port.
module lxb_checker #(
    parameter int ENTRIES = 32,
    parameter int PN_W    = 20,
    parameter int IDX_W   = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               mmu_en,
    input logic [IDX_W-1:0]   lk_base,
    input logic               req_valid,
    input logic               req_ready,
    input logic [PN_W-1:0]    req_vpn,
    input logic               resp_valid,
    input logic               resp_hit,
    input logic               resp_abort,
    input logic [PN_W-1:0]    resp_ppn,
    input logic               walk_req,
    input logic [PN_W-1:0]    walk_vpn,
    input logic               walk_ack,
    input logic [ENTRIES-1:0] match_vec,
    input logic               fill,
    input logic [IDX_W-1:0]   fill_idx
);

    p_miss_walk_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && mmu_en && (match_vec == '0)
        |=> walk_req && (walk_vpn == $past(req_vpn)));

    p_walk_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && !walk_ack |=> walk_req && $stable(walk_vpn));

    p_busy_r2: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req |-> !req_ready);

    p_ack_ends_walk_r3: assert property (@(posedge clk) disable iff (!rst_n)
        walk_req && walk_ack |=> !walk_req && !req_ready);

    p_hit_no_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid && resp_hit |-> !walk_req);

    p_single_match_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match_vec));

    p_victim_unlocked_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill |-> fill_idx >= lk_base);

    p_bypass_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready && !mmu_en
        |=> resp_valid && resp_hit && !resp_abort && (resp_ppn == $past(req_vpn)));

endmodule

bind locked_xlat_buffer lxb_checker #(
    .ENTRIES(ENTRIES), .PN_W(PN_W), .IDX_W(IDX_W)
) u_lxb_chk (
    .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .lk_base(lk_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
    .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_abort(resp_abort),
    .resp_ppn(resp_ppn), .walk_req(walk_req), .walk_vpn(walk_vpn),
    .walk_ack(walk_ack), .match_vec(match_vec), .fill(fill),
    .fill_idx(fill_idx)
);

// File: tb/tb_locked_xlat_buffer.sv
// Directed bench: one task per scenario; a background walker answers walks.
module tb_locked_xlat_buffer;

    localparam int CLK_P  = 10;
    localparam int N      = 8;
    localparam int PN     = 10;
    localparam int ND     = 16;
    localparam int AW     = 4;
    localparam int IW     = 3;
    localparam int DW     = 4;
    localparam logic [PN-1:0] XMASK = 10'h155;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic mmu_en = 1'b1;
    logic [IW-1:0] lk_base = '0;
    logic [2*ND-1:0] dom_ctl = '1;
    logic inv_unlk = 1'b0, inv_all = 1'b0;
    logic req_valid = 1'b0, req_write = 1'b0, req_priv = 1'b0;
    logic [PN-1:0] req_vpn = '0;
    logic req_ready, resp_valid, resp_hit, resp_abort, walk_req;
    logic [PN-1:0] resp_ppn, walk_vpn;
    logic [DW-1:0] resp_dom;
    logic [1:0] resp_ap;
    logic [AW-1:0] resp_attr;
    logic walk_ack = 1'b0;
    logic [PN-1:0] walk_ppn = '0;
    logic [DW-1:0] walk_dom = '0;
    logic [1:0] walk_ap = '0;
    logic [AW-1:0] walk_attr = '0;

    logic [DW-1:0] desc_dom = 4'd0;
    logic [1:0] desc_ap = 2'b11;
    int walk_cnt = 0;
    logic [PN-1:0] seen_walk_vpn = '0;

    int vec = 0, bad = 0;
    int last_lat, last_walks;
    logic last_hit, last_abort;
    logic [PN-1:0] last_ppn;
    logic [DW-1:0] last_dom;
    logic [1:0] last_ap;
    logic [AW-1:0] last_attr;

    always #(CLK_P/2) clk = ~clk;

    locked_xlat_buffer #(.ENTRIES(N), .PN_W(PN), .DOMS(ND), .ATTR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .mmu_en(mmu_en), .lk_base(lk_base),
        .dom_ctl(dom_ctl), .inv_unlk(inv_unlk), .inv_all(inv_all),
        .req_valid(req_valid), .req_ready(req_ready), .req_vpn(req_vpn),
        .req_write(req_write), .req_priv(req_priv),
        .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_abort(resp_abort),
        .resp_ppn(resp_ppn), .resp_dom(resp_dom), .resp_ap(resp_ap),
        .resp_attr(resp_attr), .walk_req(walk_req), .walk_vpn(walk_vpn),
        .walk_ack(walk_ack), .walk_ppn(walk_ppn), .walk_dom(walk_dom),
        .walk_ap(walk_ap), .walk_attr(walk_attr)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        vec++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit exp_abort(input logic [1:0] ap, input logic w, input logic p);
        case (ap)
            2'b00:   return !(p && !w);
            2'b01:   return !p;
            2'b10:   return !(p || !w);
            default: return 1'b0;
        endcase
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic pulse_inv(input bit all);
        @(negedge clk);
        if (all) inv_all = 1'b1; else inv_unlk = 1'b1;
        @(negedge clk);
        inv_all = 1'b0;
        inv_unlk = 1'b0;
    endtask

    // Issue one lookup and capture the response at a falling edge.
    task automatic lookup(input logic [PN-1:0] v, input logic w, input logic p);
        int n;
        int w0;
        w0 = walk_cnt;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1; req_vpn = v; req_write = w; req_priv = p;
        @(negedge clk);
        req_valid = 1'b0;
        n = 1;
        while (!resp_valid && n < 50) begin
            @(negedge clk);
            n++;
        end
        last_lat = n; last_hit = resp_hit; last_abort = resp_abort;
        last_ppn = resp_ppn; last_dom = resp_dom; last_ap = resp_ap;
        last_attr = resp_attr; last_walks = walk_cnt - w0;
    endtask

    task automatic expect_hit(input logic [PN-1:0] v, input string req);
        lookup(v, 1'b0, 1'b1);
        chk(last_hit === 1'b1 && last_lat == 1 && last_walks == 0, req,
            $sformatf("hit on page %0d (lat)", v), last_lat, 1);
        chk(last_ppn === (v ^ XMASK), req, "hit ppn", int'(last_ppn), int'(v ^ XMASK));
    endtask

    task automatic expect_miss(input logic [PN-1:0] v, input string req);
        lookup(v, 1'b0, 1'b1);
        chk(last_hit === 1'b0 && last_lat == 3 && last_walks == 1, req,
            $sformatf("miss+replay on page %0d (lat)", v), last_lat, 3);
        chk(last_ppn === (v ^ XMASK), req, "replay ppn", int'(last_ppn), int'(v ^ XMASK));
    endtask

    task automatic t_reset();
        do_reset();
        chk(req_ready === 1'b1, "R1", "req_ready after reset", int'(req_ready), 1);
        chk(resp_valid === 1'b0, "R1", "resp_valid after reset", int'(resp_valid), 0);
        chk(walk_req === 1'b0, "R1", "walk_req after reset", int'(walk_req), 0);
    endtask

    task automatic t_miss_fill();
        desc_dom = 4'd7; desc_ap = 2'b10;
        expect_miss(10'h010, "R1");
        chk(seen_walk_vpn === 10'h010, "R2", "walk_vpn", int'(seen_walk_vpn), 16);
        chk(last_dom === 4'd7 && last_ap === 2'b10, "R3", "replay dom/ap",
            int'({last_dom, last_ap}), int'({4'd7, 2'b10}));
        chk(last_attr === 4'h0, "R3", "replay attr", int'(last_attr), 0);
        expect_hit(10'h010, "R4");
        chk(last_dom === 4'd7 && last_ap === 2'b10 && last_attr === 4'h0, "R4",
            "hit dom/ap/attr", int'({last_attr, last_dom, last_ap}), int'({4'h0, 4'd7, 2'b10}));
        desc_dom = 4'd0; desc_ap = 2'b11;
    endtask

    task automatic t_round_robin();
        do_reset();
        for (int i = 0; i < N; i++) expect_miss(PN'(10'h100 + i), "R5");
        for (int i = 0; i < N; i++) expect_hit(PN'(10'h100 + i), "R5");
        expect_miss(10'h108, "R5");             // lands in slot 0
        for (int i = 1; i < N; i++) expect_hit(PN'(10'h100 + i), "R5");
        expect_hit(10'h108, "R5");
        expect_miss(10'h100, "R5");             // slot 0 was evicted
    endtask

    task automatic t_lock();
        do_reset();
        for (int i = 0; i < N; i++) expect_miss(PN'(10'h200 + i), "R6");
        lk_base = 3'd3;
        for (int i = 0; i < 5; i++) expect_miss(PN'(10'h280 + i), "R6");   // slots 3..7
        expect_miss(10'h285, "R6");             // wraps to slot 3
        for (int i = 0; i < 3; i++) expect_hit(PN'(10'h200 + i), "R6");
        for (int i = 1; i < 6; i++) expect_hit(PN'(10'h280 + i), "R6");
        expect_miss(10'h280, "R6");             // evicted by the wrap
    endtask

    task automatic t_inval();
        pulse_inv(1'b0);
        for (int i = 0; i < 3; i++) expect_hit(PN'(10'h200 + i), "R7");
        expect_miss(10'h283, "R7");
        pulse_inv(1'b1);
        expect_miss(10'h200, "R8");
        lk_base = 3'd0;
    endtask

    task automatic t_domains();
        do_reset();
        dom_ctl = '1;
        desc_dom = 4'd5; desc_ap = 2'b00;
        expect_miss(10'h3A0, "R9");
        dom_ctl[11:10] = 2'b00;
        lookup(10'h3A0, 1'b0, 1'b1);
        chk(last_abort === 1'b1, "R9", "no-access domain abort", int'(last_abort), 1);
        dom_ctl[11:10] = 2'b10;
        lookup(10'h3A0, 1'b0, 1'b1);
        chk(last_abort === 1'b1, "R9", "reserved domain abort", int'(last_abort), 1);
        dom_ctl = '0;
        dom_ctl[11:10] = 2'b11;
        lookup(10'h3A0, 1'b1, 1'b0);
        chk(last_abort === 1'b0, "R9", "manager domain user write", int'(last_abort), 0);
        dom_ctl = '1;
        dom_ctl[11:10] = 2'b00;
        desc_dom = 4'd4;
        expect_miss(10'h3B0, "R9");
        chk(last_abort === 1'b0, "R9", "neighbour domain unaffected", int'(last_abort), 0);
        dom_ctl = '1;
    endtask

    task automatic t_client_ap();
        do_reset();
        dom_ctl = '1;
        dom_ctl[11:10] = 2'b01;
        desc_dom = 4'd5;
        for (int a = 0; a < 4; a++) begin
            desc_ap = 2'(a);
            expect_miss(PN'(10'h040 + a), "R10");
        end
        for (int a = 0; a < 4; a++) begin
            for (int c = 0; c < 4; c++) begin
                logic w, p;
                w = c[0]; p = c[1];
                lookup(PN'(10'h040 + a), w, p);
                chk(last_abort === exp_abort(2'(a), w, p), "R10",
                    $sformatf("client ap=%0d wr=%0d priv=%0d abort", a, w, p),
                    int'(last_abort), int'(exp_abort(2'(a), w, p)));
            end
        end
        dom_ctl = '1;
        desc_dom = 4'd0; desc_ap = 2'b11;
    endtask

    task automatic t_bypass();
        mmu_en = 1'b0;
        dom_ctl = '0;
        lookup(10'h3A5, 1'b1, 1'b0);
        chk(last_hit === 1'b1 && last_lat == 1, "R11", "bypass latency", last_lat, 1);
        chk(last_ppn === 10'h3A5, "R11", "bypass ppn", int'(last_ppn), 'h3A5);
        chk(last_abort === 1'b0 && last_walks == 0, "R11", "bypass abort/walk",
            int'(last_abort) + last_walks, 0);
        chk(last_dom === '0 && last_ap === '0 && last_attr === '0, "R11",
            "bypass fields", int'({last_attr, last_dom, last_ap}), 0);
        mmu_en = 1'b1;
        dom_ctl = '1;
    endtask

    initial begin : watchdog
        #(CLK_P * 150000);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

    initial begin : walker
        forever begin
            @(negedge clk);
            if (walk_ack) begin
                walk_ack = 1'b0;
            end else if (walk_req) begin
                walk_ack = 1'b1;
                walk_ppn = walk_vpn ^ XMASK;
                walk_dom = desc_dom;
                walk_ap = desc_ap;
                walk_attr = walk_vpn[3:0];
                seen_walk_vpn = walk_vpn;
                walk_cnt++;
            end
        end
    end

    initial begin : main
        t_reset();
        t_miss_fill();
        t_round_robin();
        t_lock();
        t_inval();
        t_domains();
        t_client_ap();
        t_bypass();
        $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
        $finish;
    end

endmodule